// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block decides which exception a simple processor core takes and sequences its entry and return. It watches a reset request, a data abort strobe that lasts only one cycle, a level fast interrupt line and a level normal interrupt line. It also watches an instruction-boundary strobe and a handler-return strobe. In any cycle at most one action is chosen. An entry produces a vector, a new mode and new mask bits, and pushes the previous mode and masks onto a small saved-context stack. A return pops that stack and restores the previous context.

A data abort is taken as soon as it appears, whether or not an instruction boundary is present. If it cannot be taken in that cycle, it is held in a latch so that it is not lost. Abort entry masks only the normal interrupt. A fast interrupt that is still asserted therefore preempts the abort handler at that handler's first instruction boundary. When the fast interrupt returns, the abort handler is restored and continues.

Top module: `exc_ctrl`

Mode encoding on `mode_o`: user 0, supervisor 1, abort 2, normal interrupt 3, fast interrupt 4. Vector encoding on `vector_o`: reset 0x00, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Each output is registered and changes on the clock edge that makes the decision.

## Requirements
- R1: `reset_req_i` overrides every other input. It gives entry with vector 0x00, supervisor mode (1) and both masks set. It pushes nothing, empties the saved-context stack and discards any held abort.
- R2: A data abort (the `dabort_i` pulse or a held abort) is taken without an instruction boundary and wins over both interrupts. It gives vector 0x10 and abort mode (2).
- R3: Abort entry sets the normal-interrupt mask and leaves the fast-interrupt mask at its previous value.
- R4: A data abort that coincides with a handler return, or that arrives while the stack is full, is held. It is taken on the first later cycle in which neither condition applies.
- R5: An unmasked fast interrupt at an instruction boundary is taken ahead of the normal interrupt. It gives vector 0x1C, fast interrupt mode (4) and both masks set.
- R6: If the fast interrupt line is still high at the first instruction boundary inside the abort handler, the fast interrupt preempts that handler.
- R7: An unmasked normal interrupt at an instruction boundary gives vector 0x18 and normal interrupt mode (3), and sets only the normal-interrupt mask.
- R8: Both interrupt lines have no effect without an instruction boundary, while their mask is set, or while the stack is full.
- R9: Each entry other than reset pushes the previous mode and masks and pulses `push_o`. Each return pops and restores them in last-in, first-out order and pulses `pop_o`.
- R10: A return while the stack is empty selects user mode (0) with both masks clear and does not pulse `pop_o`.
- R11: After the asynchronous reset the block is in supervisor mode with both masks set, with no entry, push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Reset exception request |
| dabort_i | input | 1 | Data abort strobe, one cycle wide |
| fiq_i | input | 1 | Fast interrupt line, level |
| irq_i | input | 1 | Normal interrupt line, level |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| ret_i | input | 1 | Handler return strobe |
| take_o | output | 1 | Exception entry pulse |
| vector_o | output | 8 | Vector of the last entry |
| mode_o | output | 3 | Current mode |
| fiq_mask_o | output | 1 | Fast interrupt mask |
| irq_mask_o | output | 1 | Normal interrupt mask |
| push_o | output | 1 | Context push pulse |
| pop_o | output | 1 | Context pop pulse |

## Verification
Fast and normal interrupts are presented together, and then an abort is presented together with a fast interrupt; these two patterns separate the two priority levels. A run of boundary-gated fast-interrupt cycles after abort entry shows whether preemption happens and whether the fast-interrupt mask was left alone. Aborts that coincide with a return, land on a full stack or meet a reset show whether the transient pulse is held, taken late or discarded. Nested entries are unwound one return at a time, so an error in stack order shows up as a wrong restored mode or wrong mask bits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 8;

  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_SVC = 3'd1,
    MODE_ABT = 3'd2,
    MODE_IRQ = 3'd3,
    MODE_FIQ = 3'd4
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  fmask;
    logic  imask;
  } ctx_t;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_RESET, ACT_RET, ACT_ABT, ACT_FIQ, ACT_IRQ
  } act_e;

  localparam logic [VEC_W-1:0] VEC_RST = 8'h00;
  localparam logic [VEC_W-1:0] VEC_ABT = 8'h10;
  localparam logic [VEC_W-1:0] VEC_IRQ = 8'h18;
  localparam logic [VEC_W-1:0] VEC_FIQ = 8'h1C;
endpackage

// File: rtl/exc_ctx_stack.sv
module exc_ctx_stack
  import exc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic push_i,
  input  logic pop_i,
  input  ctx_t push_data_i,
  output ctx_t top_o,
  output logic full_o,
  output logic empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctx_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? ctx_t'('0) : mem[IDX_W'(cnt_q - CNT_W'(1))];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (push_i && !full_o && !clear_i && cnt_q == CNT_W'(g)) mem[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (push_i && !full_o)     cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_push_grows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !clear_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_clear_empties_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);
endmodule

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic rst_req_i,
  input  logic abort_pend_i,
  input  logic fiq_i,
  input  logic irq_i,
  input  logic bnd_i,
  input  logic ret_i,
  input  logic fmask_i,
  input  logic imask_i,
  input  logic full_i,
  output act_e act_o
);
  // return beats abort; the abort is then held and taken next cycle
  always_comb begin
    act_o = ACT_NONE;
    if (rst_req_i)                                act_o = ACT_RESET;
    else if (ret_i)                               act_o = ACT_RET;
    else if (abort_pend_i && !full_i)             act_o = ACT_ABT;
    else if (bnd_i && fiq_i && !fmask_i && !full_i) act_o = ACT_FIQ;
    else if (bnd_i && irq_i && !imask_i && !full_i) act_o = ACT_IRQ;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_req_i,
  input  logic             dabort_i,
  input  logic             fiq_i,
  input  logic             irq_i,
  input  logic             insn_bnd_i,
  input  logic             ret_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [2:0]       mode_o,
  output logic             fiq_mask_o,
  output logic             irq_mask_o,
  output logic             push_o,
  output logic             pop_o
);
  mode_e            mode_q, mode_d;
  logic             fm_q, fm_d, im_q, im_d;
  logic             lat_q, lat_d;
  logic             take_q, take_d, push_q, pop_q;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             abort_pend, full, empty, st_push, st_pop, st_clear;
  ctx_t             top;
  act_e             act;

  assign abort_pend = dabort_i | lat_q;

  exc_arb i_arb (
    .rst_req_i   (reset_req_i),
    .abort_pend_i(abort_pend),
    .fiq_i       (fiq_i),
    .irq_i       (irq_i),
    .bnd_i       (insn_bnd_i),
    .ret_i       (ret_i),
    .fmask_i     (fm_q),
    .imask_i     (im_q),
    .full_i      (full),
    .act_o       (act)
  );

  assign st_push  = (act == ACT_ABT) || (act == ACT_FIQ) || (act == ACT_IRQ);
  assign st_pop   = (act == ACT_RET) && !empty;
  assign st_clear = (act == ACT_RESET);

  exc_ctx_stack #(.DEPTH(DEPTH)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_clear),
    .push_i     (st_push),
    .pop_i      (st_pop),
    .push_data_i('{mode: mode_q, fmask: fm_q, imask: im_q}),
    .top_o      (top),
    .full_o     (full),
    .empty_o    (empty)
  );

  always_comb begin
    mode_d = mode_q;
    fm_d   = fm_q;
    im_d   = im_q;
    take_d = 1'b0;
    vec_d  = vec_q;
    lat_d  = abort_pend && (act != ACT_ABT) && (act != ACT_RESET);
    unique case (act)
      ACT_RESET: begin mode_d = MODE_SVC; fm_d = 1'b1; im_d = 1'b1; take_d = 1'b1; vec_d = VEC_RST; end
      ACT_RET: begin
        if (!empty) begin mode_d = top.mode; fm_d = top.fmask; im_d = top.imask; end
        else        begin mode_d = MODE_USR; fm_d = 1'b0;      im_d = 1'b0;      end
      end
      ACT_ABT: begin mode_d = MODE_ABT; im_d = 1'b1; take_d = 1'b1; vec_d = VEC_ABT; end
      ACT_FIQ: begin mode_d = MODE_FIQ; fm_d = 1'b1; im_d = 1'b1; take_d = 1'b1; vec_d = VEC_FIQ; end
      ACT_IRQ: begin mode_d = MODE_IRQ; im_d = 1'b1; take_d = 1'b1; vec_d = VEC_IRQ; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SVC;
      fm_q   <= 1'b1;
      im_q   <= 1'b1;
      lat_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= VEC_RST;
      push_q <= 1'b0;
      pop_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      fm_q   <= fm_d;
      im_q   <= im_d;
      lat_q  <= lat_d;
      take_q <= take_d;
      vec_q  <= vec_d;
      push_q <= st_push;
      pop_q  <= st_pop;
    end
  end

  assign take_o     = take_q;
  assign vector_o   = vec_q;
  assign mode_o     = mode_q;
  assign fiq_mask_o = fm_q;
  assign irq_mask_o = im_q;
  assign push_o     = push_q;
  assign pop_o      = pop_q;

  assert_abort_keeps_fmask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_d && vec_d == VEC_ABT) |=> (fm_q == $past(fm_q)) && im_q);

  assert_fiq_entry_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_q && vec_q == VEC_FIQ) |-> (fm_q && im_q && mode_q == MODE_FIQ));

  assert_abort_not_lost_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dabort_i |=> ((take_q && vec_q == VEC_ABT) || lat_q || $past(reset_req_i)));

  assert_push_pop_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_q && pop_q));

  assert_reset_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> (take_q && mode_q == MODE_SVC && !push_q && !lat_q));
endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr = 0, da = 0, fq = 0, iq = 0, bd = 0, rt = 0;
  logic       take, fm, im, push, pop;
  logic [7:0] vec;
  logic [2:0] mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic       take;
    logic [7:0] vec;
    logic [2:0] mode;
    logic       fm, im, push, pop;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  exc_ctrl i_exc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reset_req_i(rr), .dabort_i(da), .fiq_i(fq),
    .irq_i(iq), .insn_bnd_i(bd), .ret_i(rt), .take_o(take), .vector_o(vec),
    .mode_o(mode), .fiq_mask_o(fm), .irq_mask_o(im), .push_o(push), .pop_o(pop)
  );

  // monitor: compare one expected item per cycle, just after the edge
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (take !== e.take || mode !== e.mode || fm !== e.fm || im !== e.im ||
          push !== e.push || pop !== e.pop || (e.take && vec !== e.vec)) begin
        fails++;
        $display("FAIL %s: got take=%b vec=%h mode=%0d fm=%b im=%b push=%b pop=%b exp take=%b vec=%h mode=%0d fm=%b im=%b push=%b pop=%b",
                 e.tag, take, vec, mode, fm, im, push, pop,
                 e.take, e.vec, e.mode, e.fm, e.im, e.push, e.pop);
      end
    end
  end

  task automatic step(input logic r_rr, r_da, r_fq, r_iq, r_bd, r_rt,
                      input logic x_take, input logic [7:0] x_vec, input logic [2:0] x_mode,
                      input logic x_fm, x_im, x_push, x_pop, input string tag);
    exp_t e;
    @(negedge clk);
    rr = r_rr; da = r_da; fq = r_fq; iq = r_iq; bd = r_bd; rt = r_rt;
    e.take = x_take; e.vec = x_vec; e.mode = x_mode; e.fm = x_fm; e.im = x_im;
    e.push = x_push; e.pop = x_pop; e.tag = tag;
    expq.push_back(e);
  endtask

  initial begin
    #12;
    checks++;
    if (take !== 1'b0 || mode !== 3'd1 || fm !== 1'b1 || im !== 1'b1 || push !== 1'b0 || pop !== 1'b0) begin
      fails++;
      $display("FAIL R11: got take=%b mode=%0d fm=%b im=%b push=%b pop=%b exp 0 1 1 1 0 0",
               take, mode, fm, im, push, pop);
    end
    @(negedge clk);
    rst_n = 1'b1;
    //      rr da fq iq bd rt   take vec    mode fm im pu po
    step(0,0,0,0,0,0, 0,8'h00,3'd1, 1,1,0,0, "R11 idle after reset");
    step(0,0,1,0,1,0, 0,8'h00,3'd1, 1,1,0,0, "R8 fiq while masked");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,0, "R10 return on empty stack");
    step(0,0,1,1,1,0, 1,8'h1C,3'd4, 1,1,1,0, "R5 fiq over irq");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,1, "R9 return from fiq");
    step(0,1,1,0,1,0, 1,8'h10,3'd2, 0,1,1,0, "R2 abort over fiq");
    step(0,0,1,0,1,0, 1,8'h1C,3'd4, 1,1,1,0, "R6 fiq preempts abort handler");
    step(0,0,0,0,0,1, 0,8'h00,3'd2, 0,1,0,1, "R9 back to abort handler");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,1, "R9 back to user");
    step(0,1,0,0,0,0, 1,8'h10,3'd2, 0,1,1,0, "R2 abort without boundary");
    step(0,0,0,1,1,0, 0,8'h00,3'd2, 0,1,0,0, "R8 irq masked in abort");
    step(0,1,0,0,0,1, 0,8'h00,3'd0, 0,0,0,1, "R4 abort with return held");
    step(0,0,0,0,0,0, 1,8'h10,3'd2, 0,1,1,0, "R4 held abort taken");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,1, "R9 return to user");
    step(0,0,0,1,0,0, 0,8'h00,3'd0, 0,0,0,0, "R8 irq without boundary");
    step(0,0,0,1,1,0, 1,8'h18,3'd3, 0,1,1,0, "R7 irq entry");
    step(0,0,1,1,1,0, 1,8'h1C,3'd4, 1,1,1,0, "R5 fiq nests on irq");
    step(0,1,0,0,0,0, 1,8'h10,3'd2, 1,1,1,0, "R3 abort keeps fiq mask");
    step(0,1,0,0,0,0, 1,8'h10,3'd2, 1,1,1,0, "R2 abort fills stack");
    step(0,1,0,0,0,0, 0,8'h00,3'd2, 1,1,0,0, "R4 abort on full stack held");
    step(0,0,0,0,0,1, 0,8'h00,3'd2, 1,1,0,1, "R9 pop frees slot");
    step(0,0,0,0,0,0, 1,8'h10,3'd2, 1,1,1,0, "R4 held abort after pop");
    step(0,0,0,0,0,1, 0,8'h00,3'd2, 1,1,0,1, "R9 unwind abort");
    step(0,0,0,0,0,1, 0,8'h00,3'd4, 1,1,0,1, "R9 unwind fiq");
    step(0,0,0,0,0,1, 0,8'h00,3'd3, 0,1,0,1, "R9 unwind irq");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,1, "R9 unwind user");
    step(0,0,0,1,1,0, 1,8'h18,3'd3, 0,1,1,0, "R7 irq before reset");
    step(1,1,0,0,0,0, 1,8'h00,3'd1, 1,1,0,0, "R1 reset over abort");
    step(0,0,0,0,0,0, 0,8'h00,3'd1, 1,1,0,0, "R1 abort discarded");
    step(0,0,0,0,0,1, 0,8'h00,3'd0, 0,0,0,0, "R1 stack cleared");
    step(0,0,0,0,0,0, 0,8'h00,3'd0, 0,0,0,0, "R10 idle in user");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang at cycle %0d exp completion", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule